// File: doc/BRIEF.md
# Functional-Interrupt Recovery Controller

This block sits beside a memory test sequencer and takes over when a read-back shows the device under test in an unknown state. It starts with a soft recovery. It asks for the device's mode registers to be reloaded. It then asks the sequencer to read the memory again without writing it first. If that second read is clean enough, the event counts as soft and the sequencer resumes with the stored data intact.

If the second read still shows an unknown state, or has more errors than a programmable limit, the controller escalates. It counts a hard event and removes the device's supply enable for a programmable number of cycles. It then waits for the supply to report good and reloads the mode registers again. Because the stored data is gone after a power cycle, it tells the sequencer to rewrite the memory before the next compare. Each event counter stops at its maximum value instead of wrapping.

Top module: `fi_recovery_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: pwr_en is 1; reload_req, reread_req, busy, resume_ok and rewrite_req are 0; soft_cnt and hard_cnt are 0.
- R2: While idle, a chk_valid cycle with chk_unknown=1 raises reload_req from the next cycle. reload_req stays high until a cycle with reload_done=1, and goes low in the cycle after that one. While idle, a chk_valid cycle with chk_unknown=0 changes no output.
- R3: In the cycle after reload_done ends the first reload, reread_req is high. It stays high until a chk_valid cycle arrives, and reload_req is never high in the same cycle as reread_req.
- R4: A re-read result (chk_valid while reread_req is high) with chk_unknown=0 and chk_err_cnt <= err_thresh leads, in the next cycle, to three things: soft_cnt rises by one, resume_ok is high for exactly one cycle, and the block is idle again.
- R5: A re-read result with chk_unknown=1 or chk_err_cnt > err_thresh leads, in the next cycle, to hard_cnt rising by one and pwr_en going low.
- R6: pwr_en stays low for exactly max(off_cycles,1) cycles and then returns high. reload_req stays low until a cycle after pwr_en is high in which pwr_good=1.
- R7: After pwr_good is seen, reload_req is high until reload_done. In the next cycle rewrite_req is high for exactly one cycle. resume_ok is not raised on this path.
- R8: soft_cnt and hard_cnt saturate at 2^CNT_W-1. Further events leave them unchanged.
- R9: reload_done is ignored unless reload_req is high. chk_valid is ignored while a reload or a power cycle is in progress. Neither changes any output.
- R10: busy is high in every cycle in which the block is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | One-cycle strobe: a read phase has been classified |
| chk_unknown | input | 1 | Classification says the device is in an unknown state |
| chk_err_cnt | input | ERR_W | Error count of the classified read |
| err_thresh | input | ERR_W | Largest error count still judged a successful re-read |
| off_cycles | input | OFF_W | Number of cycles with power removed (0 treated as 1) |
| reload_done | input | 1 | Mode-register reload has completed |
| pwr_good | input | 1 | Device supply reports good |
| reload_req | output | 1 | Request a mode-register reload |
| reread_req | output | 1 | Request a re-read without rewriting |
| pwr_en | output | 1 | Device supply enable |
| busy | output | 1 | A recovery is in progress |
| resume_ok | output | 1 | One-cycle pulse: resume, data still valid |
| rewrite_req | output | 1 | One-cycle pulse: rewrite memory before next compare |
| soft_cnt | output | CNT_W | Saturating count of soft events |
| hard_cnt | output | CNT_W | Saturating count of hard events |

## Verification
The assertions assume that chk_valid and reload_done are single-cycle strobes. They also assume that err_thresh and off_cycles are held steady while a recovery is under way, and that pwr_good never rises while pwr_en is low. The bench keeps to these rules. Its supply model drops pwr_good as soon as power is removed and raises it a set number of cycles after power returns. It changes the threshold and the off time only while the block is idle.

// File: rtl/fi_recov_pkg.sv
// Shared types for the recovery controller.
package fi_recov_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RELOAD = 3'd1,
        ST_REREAD = 3'd2,
        ST_OFF    = 3'd3,
        ST_PWAIT  = 3'd4,
        ST_REINIT = 3'd5
    } rec_state_t;
endpackage

// File: rtl/fi_sat_counter.sv
// Event counter that stops at its maximum value.
// Assumes inc is a single-cycle strobe per event.
module fi_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    // Count events, holding at MAX.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/fi_off_timer.sv
// Down-counter that times how long power stays removed.
// A load value of zero behaves as one; expired is high on the last off cycle.
module fi_off_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load on entry, then count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt > 1)
            cnt <= cnt - 1'b1;
    end

    // Last cycle of the off window.
    assign expired = (cnt <= 1);
endmodule

// File: rtl/fi_recov_fsm.sv
// Recovery sequencing: soft reload plus re-read, escalating to a power cycle.
// Assumes chk_valid and reload_done are single-cycle strobes from the sequencer.
module fi_recov_fsm
    import fi_recov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_valid,
    input  logic chk_unknown,
    input  logic chk_over,
    input  logic reload_done,
    input  logic pwr_good,
    input  logic tmr_expired,
    output logic soft_inc,
    output logic hard_inc,
    output logic tmr_load,
    output logic reload_req,
    output logic reread_req,
    output logic pwr_en,
    output logic busy,
    output logic resume_ok,
    output logic rewrite_req
);
    rec_state_t st, st_nx;
    logic       resume_nx, rewrite_nx;

    // Next-state and event decode.
    always_comb begin
        st_nx      = st;
        soft_inc   = 1'b0;
        hard_inc   = 1'b0;
        tmr_load   = 1'b0;
        resume_nx  = 1'b0;
        rewrite_nx = 1'b0;
        unique case (st)
            ST_IDLE:   if (chk_valid && chk_unknown) st_nx = ST_RELOAD;
            ST_RELOAD: if (reload_done) st_nx = ST_REREAD;
            ST_REREAD: begin
                if (chk_valid) begin
                    if (!chk_unknown && !chk_over) begin
                        soft_inc  = 1'b1;
                        resume_nx = 1'b1;
                        st_nx     = ST_IDLE;
                    end else begin
                        hard_inc = 1'b1;
                        tmr_load = 1'b1;
                        st_nx    = ST_OFF;
                    end
                end
            end
            ST_OFF:    if (tmr_expired) st_nx = ST_PWAIT;
            ST_PWAIT:  if (pwr_good) st_nx = ST_REINIT;
            ST_REINIT: begin
                if (reload_done) begin
                    rewrite_nx = 1'b1;
                    st_nx      = ST_IDLE;
                end
            end
            default:   st_nx = ST_IDLE;
        endcase
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            resume_ok   <= 1'b0;
            rewrite_req <= 1'b0;
        end else begin
            st          <= st_nx;
            resume_ok   <= resume_nx;
            rewrite_req <= rewrite_nx;
        end
    end

    // Level outputs decoded from state.
    always_comb begin
        reload_req = (st == ST_RELOAD) || (st == ST_REINIT);
        reread_req = (st == ST_REREAD);
        pwr_en     = (st != ST_OFF);
        busy       = (st != ST_IDLE);
    end
endmodule

// File: rtl/fi_recovery_ctrl.sv
// Top: functional-interrupt recovery controller.
// Judges re-read quality against err_thresh, times the power-off window
// and keeps separate saturating soft and hard event counts.
// Assumes err_thresh and off_cycles are steady during a recovery.
module fi_recovery_ctrl #(
    parameter int ERR_W = 8,
    parameter int OFF_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             chk_unknown,
    input  logic [ERR_W-1:0] chk_err_cnt,
    input  logic [ERR_W-1:0] err_thresh,
    input  logic [OFF_W-1:0] off_cycles,
    input  logic             reload_done,
    input  logic             pwr_good,
    output logic             reload_req,
    output logic             reread_req,
    output logic             pwr_en,
    output logic             busy,
    output logic             resume_ok,
    output logic             rewrite_req,
    output logic [CNT_W-1:0] soft_cnt,
    output logic [CNT_W-1:0] hard_cnt
);
    logic chk_over, soft_inc, hard_inc, tmr_load, tmr_expired;

    // Re-read is too damaged when errors exceed the threshold.
    assign chk_over = (chk_err_cnt > err_thresh);

    fi_recov_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_valid   (chk_valid),
        .chk_unknown (chk_unknown),
        .chk_over    (chk_over),
        .reload_done (reload_done),
        .pwr_good    (pwr_good),
        .tmr_expired (tmr_expired),
        .soft_inc    (soft_inc),
        .hard_inc    (hard_inc),
        .tmr_load    (tmr_load),
        .reload_req  (reload_req),
        .reread_req  (reread_req),
        .pwr_en      (pwr_en),
        .busy        (busy),
        .resume_ok   (resume_ok),
        .rewrite_req (rewrite_req)
    );

    fi_off_timer #(.W(OFF_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (off_cycles),
        .run      (!pwr_en),
        .expired  (tmr_expired)
    );

    // One saturating counter per event category.
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        logic [CNT_W-1:0] cval;
        fi_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   ((g == 0) ? soft_inc : hard_inc),
            .count (cval)
        );
    end
    assign soft_cnt = g_cnt[0].cval;
    assign hard_cnt = g_cnt[1].cval;
endmodule

// File: rtl/fi_recovery_ctrl_chk.sv
// Property checker for fi_recovery_ctrl, attached by bind.
// Assumes single-cycle strobes on chk_valid and reload_done.
module fi_recovery_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reload_done,
    input logic             reload_req,
    input logic             reread_req,
    input logic             pwr_en,
    input logic             busy,
    input logic             resume_ok,
    input logic             rewrite_req,
    input logic [CNT_W-1:0] soft_cnt,
    input logic [CNT_W-1:0] hard_cnt
);
    localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reload_req && reread_req)); // R3
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resume_ok, rewrite_req})); // R7
    AST_SOFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_ok && $past(soft_cnt) != MAX) |-> soft_cnt == $past(soft_cnt) + 1'b1); // R4
    AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resume_ok |-> $stable(soft_cnt)); // R8
    AST_HARD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_en) && $past(hard_cnt) != MAX) |-> hard_cnt == $past(hard_cnt) + 1'b1); // R5
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (!reload_req && !reread_req)); // R6
    AST_REWRITE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rewrite_req) |-> ($past(reload_req) && $past(reload_done))); // R7
    AST_BUSY_COVER: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_req || reread_req || !pwr_en) |-> busy); // R10
endmodule

bind fi_recovery_ctrl fi_recovery_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reload_done (reload_done),
    .reload_req  (reload_req),
    .reread_req  (reread_req),
    .pwr_en      (pwr_en),
    .busy        (busy),
    .resume_ok   (resume_ok),
    .rewrite_req (rewrite_req),
    .soft_cnt    (soft_cnt),
    .hard_cnt    (hard_cnt)
);

// File: tb/fi_recovery_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock.
module fi_recovery_ctrl_tb_top;
    localparam int ERR_W = 8;
    localparam int OFF_W = 4;
    localparam int CNT_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chk_valid = 1'b0, chk_unknown = 1'b0;
    logic [ERR_W-1:0] chk_err_cnt = '0, err_thresh = 8'd4;
    logic [OFF_W-1:0] off_cycles = 4'd3;
    logic             reload_done = 1'b0, pwr_good = 1'b1;
    logic             reload_req, reread_req, pwr_en, busy, resume_ok, rewrite_req;
    logic [CNT_W-1:0] soft_cnt, hard_cnt;

    int checks = 0, errors = 0, cycles = 0;
    int pg_dly = 2, pg_cnt = 2;
    bit done = 0;

    // Reference model state: 0 idle,1 reload,2 reread,3 off,4 wait,5 reinit
    int m_st = 0, m_tmr = 0, m_soft = 0, m_hard = 0;
    bit m_resume = 0, m_rewrite = 0;
    localparam int MAXC = (1 << CNT_W) - 1;

    always #2.5 clk = ~clk;

    fi_recovery_ctrl #(.ERR_W(ERR_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_unknown(chk_unknown),
        .chk_err_cnt(chk_err_cnt), .err_thresh(err_thresh), .off_cycles(off_cycles),
        .reload_done(reload_done), .pwr_good(pwr_good), .reload_req(reload_req),
        .reread_req(reread_req), .pwr_en(pwr_en), .busy(busy), .resume_ok(resume_ok),
        .rewrite_req(rewrite_req), .soft_cnt(soft_cnt), .hard_cnt(hard_cnt));

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        m_resume = 0;
        m_rewrite = 0;
        if (!rst_n) begin
            m_st = 0; m_tmr = 0; m_soft = 0; m_hard = 0;
        end else begin
            case (m_st)
                0: if (chk_valid && chk_unknown) m_st = 1;
                1: if (reload_done) m_st = 2;
                2: if (chk_valid) begin
                       if (!chk_unknown && int'(chk_err_cnt) <= int'(err_thresh)) begin
                           if (m_soft < MAXC) m_soft++;
                           m_resume = 1; m_st = 0;
                       end else begin
                           if (m_hard < MAXC) m_hard++;
                           m_tmr = (off_cycles == 0) ? 1 : int'(off_cycles);
                           m_st = 3;
                       end
                   end
                3: if (m_tmr <= 1) m_st = 4; else m_tmr--;
                4: if (pwr_good) m_st = 5;
                5: if (reload_done) begin m_rewrite = 1; m_st = 0; end
                default: m_st = 0;
            endcase
        end
    end

    // Compare every output on the falling edge, then update the supply model.
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(reload_req),  (m_st == 1 || m_st == 5) ? 1 : 0, "R2 reload_req");
            check(int'(reread_req),  (m_st == 2) ? 1 : 0, "R3 reread_req");
            check(int'(pwr_en),      (m_st != 3) ? 1 : 0, "R6 pwr_en");
            check(int'(busy),        (m_st != 0) ? 1 : 0, "R10 busy");
            check(int'(resume_ok),   int'(m_resume), "R4 resume_ok");
            check(int'(rewrite_req), int'(m_rewrite), "R7 rewrite_req");
            check(int'(soft_cnt),    m_soft, "R4 soft_cnt");
            check(int'(hard_cnt),    m_hard, "R5 hard_cnt");
        end
        #1;
        if (!pwr_en) begin
            pg_cnt = 0; pwr_good = 1'b0;
        end else if (pg_cnt < pg_dly) begin
            pg_cnt++;
        end else begin
            pwr_good = 1'b1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic chk_pulse(input bit unk, input int err);
        @(negedge clk); #1;
        chk_valid = 1'b1; chk_unknown = unk; chk_err_cnt = ERR_W'(err);
        @(negedge clk); #1;
        chk_valid = 1'b0; chk_unknown = 1'b0; chk_err_cnt = '0;
    endtask

    task automatic done_pulse();
        @(negedge clk); #1;
        reload_done = 1'b1;
        @(negedge clk); #1;
        reload_done = 1'b0;
    endtask

    // Full recovery; the re-read outcome is given by unk/err.
    task automatic recovery(input bit unk, input int err);
        chk_pulse(1'b1, 0);
        step(2);
        done_pulse();
        step(1);
        chk_pulse(unk, err);
        while (busy) begin
            if (reload_req && pwr_en && m_st == 5) done_pulse();
            else step(1);
        end
        step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check(int'(pwr_en), 1, "R1 pwr_en");
        check(int'(busy | reload_req | reread_req | resume_ok | rewrite_req), 0, "R1 requests");
        check(int'(soft_cnt) + int'(hard_cnt), 0, "R1 counters");

        // R2 / R9: benign read and stray reload_done in idle are ignored
        chk_pulse(1'b0, 9);
        done_pulse();
        step(2);
        check(int'(busy), 0, "R9 idle after stray strobes");

        // R4: soft recovery at threshold boundary
        recovery(1'b0, 4);
        check(int'(soft_cnt), 1, "R4 soft at threshold");
        // R5 / R6 / R7: error count one over threshold escalates
        recovery(1'b0, 5);
        check(int'(hard_cnt), 1, "R5 hard over threshold");
        // unknown on re-read, zero off time, slow supply
        off_cycles = 4'd0; pg_dly = 5;
        recovery(1'b1, 0);
        check(int'(hard_cnt), 2, "R6 zero off window");

        // R9: chk_valid during reload and during power-off ignored
        off_cycles = 4'd6; pg_dly = 1;
        chk_pulse(1'b1, 0);
        chk_pulse(1'b0, 0);
        done_pulse();
        step(1);
        chk_pulse(1'b1, 0);
        chk_pulse(1'b0, 0);
        check(int'(pwr_en), 0, "R9 still off after stray chk_valid");
        while (busy) begin
            if (reload_req && m_st == 5) done_pulse(); else step(1);
        end
        step(1);
        check(int'(soft_cnt), 1, "R9 soft unchanged");

        // R8: saturation of both counters
        err_thresh = 8'd0; off_cycles = 4'd2;
        for (int k = 0; k < 9; k++) recovery(1'b0, 0);
        for (int k = 0; k < 8; k++) recovery(1'b0, 1);
        check(int'(soft_cnt), MAXC, "R8 soft saturated");
        check(int'(hard_cnt), MAXC, "R8 hard saturated");
        finish_run();
    end
endmodule